// File: doc/BRIEF.md
# Gated Pulse-Width Capture Timer

This block is a free-running up-counter that can be paused by the signal it measures, so the count it reaches is the width of a pulse on one input pin. A power-of-two prescaler turns the system clock into counter ticks. When gating is on, the counter moves only while the synchronized pin sits at the chosen active level. A programmable edge on the same pin copies the count into a capture register. The same edge can also load the counter with a reload value. This lets a stream of pulses be measured one after another with no software restart between them.

Two sticky flags record capture events and counter wrap-around. Software clears each flag by writing zero to its bit. A single enable bit routes the flags to an interrupt line. Software reaches the control, status, count, reload and capture registers through a simple single-cycle write strobe and a combinational read port.

Top module: `gpw_capture_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The control field div (bits 2:0) sets the tick rate to one tick every 2^div clocks. Code 000 ticks every clock and code 111 every 128 clocks. The count advances by one per tick while counting is allowed.
- R3: With gate enable (control bit 5) set, the counter advances only while the synchronized pin matches the active level. Polarity (control bit 6) at 0 counts while the pin is high, and at 1 counts while the pin is low. With gate enable clear, every tick counts.
- R4: The pin passes through two flip-flops before edge detection. Edge select (control bits 4:3) chooses the capture edge: 01 rising, 10 falling, 11 both, 00 none. A detected edge copies the count into the capture register on the next tick. With div 000 and matching gating, a pin pulse lasting N clocks captures N.
- R5: With reload-on-capture (control bit 7) set, the counter takes the reload value in the same tick as the capture. With the bit clear, the counter keeps counting.
- R6: Each capture sets status bit 1. The bit stays set until software writes 0 to it. Writing 1 to it has no effect.
- R7: A counting tick at count FFFFh wraps the counter to 0 and sets status bit 3. The bit is cleared by writing 0 to it.
- R8: When a capture and a wrap fall in the same tick, both status bits are set, the capture register holds FFFFh, and the counter takes the reload value when reload-on-capture is set.
- R9: `irq` is high exactly while the interrupt enable (control bit 9) is set and at least one status flag is set.
- R10: While run (control bit 8) is clear, the count, the capture register and the flags do not change on their own. Register writes still take effect.
- R11: Register addresses are 0 control, 1 status, 2 count (read/write), 3 reload (read/write) and 4 capture (read only; writes ignored). Any other address reads 0. A software write to the count takes priority over a hardware update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| pin_in | input | 1 | Measured signal, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The capture event and the counter wrap can fall in the same tick. In that tick the counter has two claims on it: the reload load and the wrap to zero. Both flags also want to set. The bench provokes this by parking the counter at FFFFh with the slowest prescaler and raising the pin well before the tick. The edge is then held pending until the tick that also wraps. The bench judges the result by reading a status of 000Ah, a capture of FFFFh and the counter at the reload value. It also confirms that the status still read zero while the edge was pending.

// File: rtl/gpw_pkg.sv
`timescale 1ns/1ps
package gpw_pkg;
   parameter int CODE_W  = 3;   // prescaler code width
   parameter int ADDR_W  = 3;
   parameter int CAP_BIT = 1;   // status bit of the capture flag
   parameter int OVF_BIT = 3;   // status bit of the wrap flag

   typedef enum logic [ADDR_W-1:0] {
      A_CTRL = 3'd0,
      A_STAT = 3'd1,
      A_CNT  = 3'd2,
      A_RLD  = 3'd3,
      A_CAP  = 3'd4
   } reg_addr_e;

   typedef struct packed {
      logic              irq_en;    // bit 9
      logic              run;       // bit 8
      logic              rld_cap;   // bit 7
      logic              gate_pol;  // bit 6
      logic              gate_en;   // bit 5
      logic [1:0]        edge_sel;  // bits 4:3
      logic [CODE_W-1:0] div_code;  // bits 2:0
   } ctrl_t;
endpackage

// File: rtl/gpw_sync_edge.sv
`timescale 1ns/1ps
module gpw_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic level,
   output logic rise,
   output logic fall
);
   // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin};
   end

   assign level = chain[STAGES-1];
   assign rise  =  chain[STAGES-1] & ~chain[STAGES];
   assign fall  = ~chain[STAGES-1] &  chain[STAGES];
endmodule

// File: rtl/gpw_prescaler.sv
`timescale 1ns/1ps
module gpw_prescaler #(
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int PS_W = (1 << CODE_W) - 1;

   generate
      if (PS_W == 1) begin : g_single
         logic phase;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           phase <= 1'b0;
            else if (!run || tick) phase <= 1'b0;
            else                  phase <= 1'b1;
         end
         assign tick = run && (code == '0 || phase);
      end else begin : g_multi
         logic [PS_W-1:0] div_cnt;
         logic [PS_W-1:0] limit;
         assign limit = ~({PS_W{1'b1}} << code);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            div_cnt <= '0;
            else if (!run || tick) div_cnt <= '0;
            else                   div_cnt <= div_cnt + 1'b1;
         end
         assign tick = run && (div_cnt == limit);
      end
   endgenerate
endmodule

// File: rtl/gpw_count_core.sv
`timescale 1ns/1ps
module gpw_count_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             gate_ok,
   input  logic             edge_hit,
   input  logic             rld_cap,
   input  logic [CNT_W-1:0] reload,
   input  logic             sw_wr,
   input  logic [CNT_W-1:0] sw_val,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] capture,
   output logic             cap_evt,
   output logic             ovf_evt
);
   logic edge_pend;
   logic inc;

   assign cap_evt = tick && (edge_hit || edge_pend);
   assign inc     = tick && gate_ok;
   assign ovf_evt = inc && (count == {CNT_W{1'b1}});

   // an edge seen between ticks waits for the next tick
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              edge_pend <= 1'b0;
      else if (!run || tick)   edge_pend <= 1'b0;
      else if (edge_hit)       edge_pend <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  count <= '0;
      else if (sw_wr)              count <= sw_val;
      else if (cap_evt && rld_cap) count <= reload;
      else if (inc)                count <= count + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       capture <= '0;
      else if (cap_evt) capture <= count;
   end
endmodule

// File: rtl/gpw_capture_timer.sv
`timescale 1ns/1ps
module gpw_capture_timer
   import gpw_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [CNT_W-1:0]  reg_wdata,
   output logic [CNT_W-1:0]  reg_rdata,
   input  logic              pin_in,
   output logic              irq
);
   localparam int CTRL_W = $bits(ctrl_t);

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("CNT_W must hold the control register");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] capture_q;
   logic             cap_flag, ovf_flag;
   logic             run, rld_en, irq_en;
   logic             tick, cap_evt, ovf_evt;
   logic             pin_lvl, pin_rise, pin_fall;
   logic             gate_ok, edge_hit;
   logic             ctrl_wr, stat_wr, cnt_wr, rld_wr;

   assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
   assign stat_wr = reg_wr && (reg_addr == A_STAT);
   assign cnt_wr  = reg_wr && (reg_addr == A_CNT);
   assign rld_wr  = reg_wr && (reg_addr == A_RLD);

   assign run    = ctrl_q.run;
   assign rld_en = ctrl_q.rld_cap;
   assign irq_en = ctrl_q.irq_en;

   gpw_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(pin_in),
      .level(pin_lvl), .rise(pin_rise), .fall(pin_fall)
   );

   gpw_prescaler #(.CODE_W(CODE_W)) u_presc (
      .clk(clk), .rst_n(rst_n), .run(run),
      .code(ctrl_q.div_code), .tick(tick)
   );

   assign gate_ok  = !ctrl_q.gate_en || (pin_lvl ^ ctrl_q.gate_pol);
   assign edge_hit = (ctrl_q.edge_sel[0] && pin_rise) ||
                     (ctrl_q.edge_sel[1] && pin_fall);

   gpw_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
      .gate_ok(gate_ok), .edge_hit(edge_hit), .rld_cap(rld_en),
      .reload(reload_q), .sw_wr(cnt_wr), .sw_val(reg_wdata),
      .count(count_q), .capture(capture_q),
      .cap_evt(cap_evt), .ovf_evt(ovf_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (ctrl_wr) ctrl_q   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (rld_wr)  reload_q <= reg_wdata;
      end
   end

   // hardware set wins over a software clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_flag <= 1'b0;
         ovf_flag <= 1'b0;
      end else begin
         cap_flag <= cap_evt || (cap_flag && !(stat_wr && !reg_wdata[CAP_BIT]));
         ovf_flag <= ovf_evt || (ovf_flag && !(stat_wr && !reg_wdata[OVF_BIT]));
      end
   end

   assign irq = irq_en && (cap_flag || ovf_flag);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL: reg_rdata = CNT_W'(ctrl_q);
         A_STAT: begin
            reg_rdata[CAP_BIT] = cap_flag;
            reg_rdata[OVF_BIT] = ovf_flag;
         end
         A_CNT:  reg_rdata = count_q;
         A_RLD:  reg_rdata = reload_q;
         A_CAP:  reg_rdata = capture_q;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpw_capture_timer_chk.sv
`timescale 1ns/1ps
module gpw_capture_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run,
   input logic             tick,
   input logic             cap_evt,
   input logic             ovf_evt,
   input logic             cnt_wr,
   input logic             rld_en,
   input logic             irq_en,
   input logic             cap_flag,
   input logic             ovf_flag,
   input logic             irq,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] reload
);
   assert_tick_needs_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> run);

   assert_reload_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt && rld_en && !cnt_wr) |=> (count == $past(reload)));

   assert_cap_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_flag) |-> $past(cap_evt));

   assert_ovf_flag_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf_flag);

   assert_ovf_wraps_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_evt && !cap_evt && !cnt_wr) |=> (count == '0));

   assert_irq_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en);

   assert_hold_when_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!run) && $past(!cnt_wr)) |-> $stable(count));
endmodule

bind gpw_capture_timer gpw_capture_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
   .cap_evt(cap_evt), .ovf_evt(ovf_evt), .cnt_wr(cnt_wr),
   .rld_en(rld_en), .irq_en(irq_en), .cap_flag(cap_flag),
   .ovf_flag(ovf_flag), .irq(irq), .count(count_q), .reload(reload_q)
);

// File: tb/sim_gpw_capture_timer.sv
`timescale 1ns/1ps
module sim_gpw_capture_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        pin_in = 1'b0;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   logic [15:0] v, c, n;

   always #2 clk = ~clk;   // 250 MHz

   gpw_capture_timer u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in), .irq(irq)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk);
      #1 reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #0.5 d = reg_rdata;
   endtask

   task automatic pulse(input logic lvl, input int len);
      @(negedge clk) pin_in = lvl;
      repeat (len) @(negedge clk);
      pin_in = ~lvl;
   endtask

   task automatic t_reset;
      for (int a = 0; a < 5; a++) begin
         rd(a[2:0], v);
         check("R1 register zero after reset", v, 16'h0);
      end
      check("R1 irq low after reset", {15'b0, irq}, 16'h0);
   endtask

   task automatic t_high_pulse;
      wr(3'd3, 16'h0000);
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'h03B0);   // falling edge, gate pol0, reload, run, irq
      repeat (4) @(posedge clk);
      pulse(1'b1, 25);
      repeat (8) @(posedge clk);
      rd(3'd4, v); check("R4 R3 high pulse width 25", v, 16'd25);
      rd(3'd2, v); check("R5 counter reloaded to 0", v, 16'h0);
      rd(3'd1, v); check("R6 capture flag set", v, 16'h0002);
      check("R9 irq with enable and flag", {15'b0, irq}, 16'h1);
      pulse(1'b1, 10);
      repeat (8) @(posedge clk);
      rd(3'd4, v); check("R5 back-to-back pulse width 10", v, 16'd10);
      wr(3'd1, 16'h0002);
      rd(3'd1, v); check("R6 write 1 keeps flag", v, 16'h0002);
      wr(3'd1, 16'h0000);
      rd(3'd1, v); check("R6 write 0 clears flag", v, 16'h0000);
      check("R9 irq low after clear", {15'b0, irq}, 16'h0);
   endtask

   task automatic t_low_pulse;
      wr(3'd0, 16'h0000);
      pin_in = 1'b1;
      repeat (4) @(posedge clk);
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'h01E8);   // rising edge, gate pol1, reload, run
      repeat (4) @(posedge clk);
      pulse(1'b0, 17);
      repeat (8) @(posedge clk);
      rd(3'd4, v); check("R3 R4 low pulse width 17", v, 16'd17);
      wr(3'd1, 16'h0000);
   endtask

   task automatic t_no_reload;
      wr(3'd0, 16'h0000);
      pin_in = 1'b0;
      repeat (4) @(posedge clk);
      wr(3'd2, 16'd100);
      wr(3'd3, 16'h5000);
      wr(3'd0, 16'h0108);   // rising edge, no gate, no reload, run
      repeat (20) @(posedge clk);
      pin_in = 1'b1;
      repeat (10) @(posedge clk);
      rd(3'd4, c);
      rd(3'd2, n);
      check("R5 capture above start", {15'b0, (c > 16'd100)}, 16'h1);
      check("R5 no reload, counter kept counting", {15'b0, (n > c && n < 16'h5000)}, 16'h1);
      wr(3'd1, 16'h0000);
   endtask

   task automatic t_prescale;
      wr(3'd0, 16'h0000);
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'h0103);   // div code 3, run
      repeat (40) @(posedge clk);
      rd(3'd2, v); check("R2 div 8 after 40 clocks", v, 16'd5);
      wr(3'd0, 16'h0000);
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'h0107);   // div code 7, run
      repeat (127) @(posedge clk);
      rd(3'd2, v); check("R2 div 128 before first tick", v, 16'd0);
      @(posedge clk);
      rd(3'd2, v); check("R2 div 128 first tick", v, 16'd1);
   endtask

   task automatic t_overflow;
      wr(3'd0, 16'h0000);
      wr(3'd1, 16'h0000);
      wr(3'd2, 16'hFFFE);
      wr(3'd0, 16'h0300);   // run, irq enable, no edges
      repeat (6) @(posedge clk);
      rd(3'd1, v); check("R7 wrap flag set", v, 16'h0008);
      check("R9 irq on wrap flag", {15'b0, irq}, 16'h1);
      rd(3'd2, v); check("R7 counter wrapped to 0", {15'b0, (v < 16'd16)}, 16'h1);
      wr(3'd1, 16'h0000);
      rd(3'd1, v); check("R7 wrap flag cleared", v, 16'h0000);
   endtask

   task automatic t_both;
      wr(3'd0, 16'h0000);
      pin_in = 1'b0;
      repeat (4) @(posedge clk);
      wr(3'd3, 16'h1234);
      wr(3'd2, 16'hFFFF);
      wr(3'd0, 16'h018F);   // div 128, rising edge, reload, run, no irq
      pin_in = 1'b1;
      repeat (100) @(posedge clk);
      rd(3'd1, v); check("R4 edge pending until tick", v, 16'h0000);
      repeat (34) @(posedge clk);
      rd(3'd1, v); check("R8 both flags set", v, 16'h000A);
      rd(3'd4, v); check("R8 capture holds FFFF", v, 16'hFFFF);
      rd(3'd2, v); check("R8 counter took reload", v, 16'h1234);
      check("R9 irq masked when disabled", {15'b0, irq}, 16'h0);
      wr(3'd1, 16'h0008);
      rd(3'd1, v); check("R6 clear capture flag only", v, 16'h0008);
      wr(3'd1, 16'h0000);
   endtask

   task automatic t_stop;
      wr(3'd0, 16'h0098);   // both edges, reload, run clear
      wr(3'd2, 16'h0042);
      for (int i = 0; i < 3; i++) begin
         pulse(~pin_in, 6);
         repeat (4) @(posedge clk);
      end
      rd(3'd2, v); check("R10 count held while stopped", v, 16'h0042);
      rd(3'd4, v); check("R10 capture held while stopped", v, 16'hFFFF);
      rd(3'd1, v); check("R10 flags held while stopped", v, 16'h0000);
      wr(3'd3, 16'h0055);
      rd(3'd3, v); check("R10 R11 reload write while stopped", v, 16'h0055);
      wr(3'd4, 16'h7777);
      rd(3'd4, v); check("R11 capture write ignored", v, 16'hFFFF);
      rd(3'd6, v); check("R11 unused address reads 0", v, 16'h0000);
      rd(3'd0, v); check("R11 control readback", v, 16'h0098);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_high_pulse();
      t_low_pulse();
      t_no_reload();
      t_prescale();
      t_overflow();
      t_both();
      t_stop();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule